// File: doc/BRIEF.md
# Cache Line Health Monitor

This block watches the error events that a cache's ECC logic reports and turns them into a health indication. It does not count raw corrections. For every cache line it keeps track of whether that line has been corrected once already. The block counts a line when the line is corrected a second time. The number of such distinct lines is compared with a threshold that can be changed at run time. The status is green while the count is at or below the threshold and yellow once the count is above it.

Uncorrected events are reported on a separate, sticky flag that is more severe than yellow. This flag does not depend on the green/yellow status, because a double-bit failure in one ECC block can happen while the cache is still green. A constant capability output tells software that this threshold-based status is present. A single clear pulse returns all tracking state to empty.

Top module: `cache_health_mon`

## Requirements
- R1: `tes_cap_o` is 1 at all times after reset is released.
- R2: The first corrected event on a line leaves `affected_cnt_o` unchanged. The second corrected event on the same line raises it by one in the cycle after the event.
- R3: Corrected events on a line that is already counted do not change `affected_cnt_o`.
- R4: `status_yellow_o` is 1 (yellow) when `affected_cnt_o` is greater than `thresh_i`, and 0 (green) otherwise. It follows a change of `thresh_i` within the same cycle, with no clock edge needed.
- R5: An event with `evt_uncorr_i`=1 sets `uncorr_o` in the cycle after the event, whatever the status. The flag stays set until a clear. The event does not change any line's tracking state or the count.
- R6: `affected_cnt_o` saturates at 2^CNT_W-1 and never wraps.
- R7: A `clr_i` pulse empties all per-line state, the count and `uncorr_o` on the next edge. An event in the same cycle as the clear is discarded.
- R8: An event whose line index is NUM_LINES or above is ignored.
- R9: After reset the count is 0, the status is green and `uncorr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear pulse; wins over a simultaneous event |
| evt_valid_i | input | 1 | One ECC event this cycle |
| evt_line_i | input | IDX_W | Line (ECC block) index of the event |
| evt_uncorr_i | input | 1 | 1 = uncorrected event, 0 = corrected event |
| thresh_i | input | CNT_W | Affected-line threshold |
| status_yellow_o | output | 1 | 0 = green, 1 = yellow |
| affected_cnt_o | output | CNT_W | Number of distinct lines corrected more than once |
| uncorr_o | output | 1 | Sticky uncorrected-error flag |
| tes_cap_o | output | 1 | Threshold-based status supported (constant 1) |

## Verification
The bench repeats corrections on the same line. A design that counts raw events instead of distinct lines would let the count climb there. It sends an uncorrected event on an unseen line and then one correction on that line. A design that treats the uncorrected event as a first correction would count the line too early. It clears in the same cycle as an event on an already affected line and then corrects that line once. Stale per-line bits or an event that wins over the clear would then show as a nonzero count. It also drives more lines than the counter can hold, sends indices beyond the last line, and moves the threshold without a clock edge. These tests catch a count that wraps, indices that alias onto real lines, and a status that is registered instead of computed live.

// File: rtl/chm_pkg.sv
package chm_pkg;
  typedef enum logic {
    HEALTH_GREEN  = 1'b0,
    HEALTH_YELLOW = 1'b1
  } health_e;
endpackage

// File: rtl/chm_line_table.sv
module chm_line_table #(
  parameter int NUM_LINES = 48,
  parameter int IDX_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             corr_i,
  input  logic [IDX_W-1:0] line_i,
  output logic             newly_aff_o
);
  logic [NUM_LINES-1:0] seen_q, aff_q;
  logic sel_seen, sel_aff, sel_hit;

  always_comb begin
    sel_seen = 1'b0;
    sel_aff  = 1'b0;
    sel_hit  = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (line_i == IDX_W'(i)) begin
        sel_seen = seen_q[i];
        sel_aff  = aff_q[i];
        sel_hit  = 1'b1;
      end
    end
  end

  // first correction marks seen, a later one marks affected
  assign newly_aff_o = corr_i && !clr_i && sel_hit && sel_seen && !sel_aff;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic hit;
    assign hit = corr_i && (line_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        seen_q[g] <= 1'b0;
        aff_q[g]  <= 1'b0;
      end else if (clr_i) begin
        seen_q[g] <= 1'b0;
        aff_q[g]  <= 1'b0;
      end else if (hit) begin
        if (seen_q[g]) aff_q[g] <= 1'b1;
        seen_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/chm_sat_counter.sv
module chm_sat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/chm_status.sv
module chm_status
  import chm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thresh_i,
  output health_e          status_o
);
  assign status_o = (cnt_i > thresh_i) ? HEALTH_YELLOW : HEALTH_GREEN;
endmodule

// File: rtl/cache_health_mon.sv
module cache_health_mon
  import chm_pkg::*;
#(
  parameter int NUM_LINES = 48,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             evt_valid_i,
  input  logic [IDX_W-1:0] evt_line_i,
  input  logic             evt_uncorr_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             status_yellow_o,
  output logic [CNT_W-1:0] affected_cnt_o,
  output logic             uncorr_o,
  output logic             tes_cap_o
);
  logic    corr_evt, newly_aff, uncorr_q;
  health_e status;

  assign corr_evt = evt_valid_i && !evt_uncorr_i;

  chm_line_table #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .corr_i     (corr_evt),
    .line_i     (evt_line_i),
    .newly_aff_o(newly_aff)
  );

  chm_sat_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .inc_i (newly_aff),
    .cnt_o (affected_cnt_o)
  );

  chm_status #(.CNT_W(CNT_W)) i_status (
    .cnt_i   (affected_cnt_o),
    .thresh_i(thresh_i),
    .status_o(status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          uncorr_q <= 1'b0;
    else if (clr_i)                       uncorr_q <= 1'b0;
    else if (evt_valid_i && evt_uncorr_i) uncorr_q <= 1'b1;
  end

  assign uncorr_o        = uncorr_q;
  assign status_yellow_o = (status == HEALTH_YELLOW);
  assign tes_cap_o       = 1'b1;
endmodule

// File: rtl/chm_checker.sv
module chm_checker #(
  parameter int NUM_LINES = 48,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             evt_valid_i,
  input logic [IDX_W-1:0] evt_line_i,
  input logic             evt_uncorr_i,
  input logic [CNT_W-1:0] thresh_i,
  input logic             status_yellow_o,
  input logic [CNT_W-1:0] affected_cnt_o,
  input logic             uncorr_o,
  input logic             tes_cap_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;
  localparam logic [IDX_W:0]   LinesL = (IDX_W+1)'(NUM_LINES);

  a_r1_cap_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tes_cap_o);

  a_r3_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (affected_cnt_o == $past(affected_cnt_o)) ||
               (affected_cnt_o == $past(affected_cnt_o) + CNT_W'(1)));

  a_r4_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_yellow_o == (affected_cnt_o > thresh_i));

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o && !clr_i |=> uncorr_o);

  a_r5_uncorr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && evt_uncorr_i && !clr_i |=> uncorr_o);

  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    affected_cnt_o == CntMax && !clr_i |=> affected_cnt_o == CntMax);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> affected_cnt_o == '0 && !uncorr_o);

  a_r8_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i && !clr_i && ({1'b0, evt_line_i} >= LinesL) |=>
      $stable(affected_cnt_o));
endmodule

bind cache_health_mon chm_checker #(
  .NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .IDX_W(IDX_W)
) i_chm_checker (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clr_i          (clr_i),
  .evt_valid_i    (evt_valid_i),
  .evt_line_i     (evt_line_i),
  .evt_uncorr_i   (evt_uncorr_i),
  .thresh_i       (thresh_i),
  .status_yellow_o(status_yellow_o),
  .affected_cnt_o (affected_cnt_o),
  .uncorr_o       (uncorr_o),
  .tes_cap_o      (tes_cap_o)
);

// File: tb/test_cache_health_mon.sv
`timescale 1ns/1ps
module test_cache_health_mon;
  localparam int NL = 48;
  localparam int CW = 4;
  localparam int IW = 6;
  localparam int MAXC = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr = 1'b0, evt_valid = 1'b0, evt_uncorr = 1'b0;
  logic [IW-1:0] evt_line = '0;
  logic [CW-1:0] thresh = '0;
  logic yellow, uncorr, cap;
  logic [CW-1:0] cnt;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int m_seen[NL], m_aff[NL];
  int m_cnt = 0;
  bit m_unc = 1'b0;

  always #2 clk = ~clk;

  cache_health_mon #(.NUM_LINES(NL), .CNT_W(CW), .IDX_W(IW)) i_cache_health_mon (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .evt_valid_i(evt_valid),
    .evt_line_i(evt_line), .evt_uncorr_i(evt_uncorr), .thresh_i(thresh),
    .status_yellow_o(yellow), .affected_cnt_o(cnt), .uncorr_o(uncorr),
    .tes_cap_o(cap)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(int'(cnt) == m_cnt, req, "count", int'(cnt), m_cnt);
    chk(yellow == (m_cnt > int'(thresh)), req, "yellow", int'(yellow),
        int'(m_cnt > int'(thresh)));
    chk(uncorr == m_unc, req, "uncorr", int'(uncorr), int'(m_unc));
    chk(cap == 1'b1, "R1", "cap", int'(cap), 1);
  endtask

  task automatic model_edge(input bit v, input int ln, input bit u, input bit c);
    if (c) begin
      for (int i = 0; i < NL; i++) begin m_seen[i] = 0; m_aff[i] = 0; end
      m_cnt = 0;
      m_unc = 1'b0;
    end else if (v) begin
      if (u) m_unc = 1'b1;
      else if (ln < NL) begin
        if (m_seen[ln] != 0 && m_aff[ln] == 0) begin
          m_aff[ln] = 1;
          if (m_cnt < MAXC) m_cnt++;
        end
        m_seen[ln] = 1;
      end
    end
  endtask

  task automatic step(input bit v, input int ln, input bit u, input bit c,
                      input string req);
    evt_valid  = v;
    evt_line   = IW'(ln);
    evt_uncorr = u;
    clr        = c;
    @(posedge clk);
    model_edge(v, ln, u, c);
    #1;
    compare(req);
    evt_valid = 1'b0;
    clr       = 1'b0;
  endtask

  task automatic set_thr(input int t, input string req);
    thresh = CW'(t);
    #1;
    compare(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_seen[i] = 0; m_aff[i] = 0; end
    thresh = CW'(2);
    #1;
    compare("R9");
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1'b0, 0, 1'b0, 1'b0, "R9");

    // R2: first correction not counted, second counted
    step(1'b1, 5, 1'b0, 1'b0, "R2");
    step(1'b1, 5, 1'b0, 1'b0, "R2");
    // R3: repeats on affected line
    for (int k = 0; k < 3; k++) step(1'b1, 5, 1'b0, 1'b0, "R3");

    // R4: cross threshold, then move it live
    step(1'b1, 7, 1'b0, 1'b0, "R4");
    step(1'b1, 7, 1'b0, 1'b0, "R4");
    step(1'b1, 9, 1'b0, 1'b0, "R4");
    step(1'b1, 9, 1'b0, 1'b0, "R4");
    set_thr(3, "R4");
    set_thr(0, "R4");
    set_thr(15, "R4");

    // R5: uncorrected while green, no line state touched
    step(1'b1, 20, 1'b1, 1'b0, "R5");
    step(1'b1, 20, 1'b0, 1'b0, "R5");
    step(1'b0, 0, 1'b0, 1'b0, "R5");
    step(1'b1, 20, 1'b0, 1'b0, "R5");

    // R8: out-of-range indices
    step(1'b1, 50, 1'b0, 1'b0, "R8");
    step(1'b1, 50, 1'b0, 1'b0, "R8");
    step(1'b1, 63, 1'b0, 1'b0, "R8");
    step(1'b1, 63, 1'b0, 1'b0, "R8");

    // R7: clear with simultaneous event, then per-line state empty
    step(1'b1, 7, 1'b0, 1'b1, "R7");
    step(1'b1, 7, 1'b0, 1'b0, "R7");
    step(1'b1, 11, 1'b1, 1'b1, "R7");

    // R6: saturation
    for (int ln = 0; ln < 20; ln++) begin
      step(1'b1, ln, 1'b0, 1'b0, "R6");
      step(1'b1, ln, 1'b0, 1'b0, "R6");
    end
    set_thr(14, "R6");
    set_thr(15, "R6");
    step(1'b0, 0, 1'b0, 1'b1, "R7");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule